// File: doc/BRIEF.md
# PLL Lock-Loss Status Registers

This block keeps status for two phase-locked loops. It watches the digital lock-detect signal of each loop. For each loop it reports the current lock level and a sticky flag that records that lock was lost. Each loop also has a software clear-control bit, and the status of each loop appears as one 8-bit register on a simple synchronous register bus.

The lock-detect inputs are asynchronous to the bus clock. Each one passes through a two-flop synchronizer. Only a high-to-low transition of the synchronized level sets the sticky flag. A low level on its own never sets it.

Software clears the flag by writing the clear-control bit to 1 and then back to 0. While that bit is 1 the flag is held at 0. If the clear is released while lock is already low, the flag stays at 0 until a new falling edge arrives.

A separate output tells whether the second loop's lost flag can be trusted. This depends on whether the lock-detect output multiplexer selects that loop's detector.

Top module: `pll_lock_status`

## Requirements
- R1: A read presents `rd_addr` and returns the register one clock later on `rd_data`. Address 0x182 holds the first loop's status and 0x183 holds the second loop's. In each status byte, bit 2 is the sticky lost flag, bit 1 is the live lock level, bit 0 is the clear-control bit, and bits 7:3 read as 0. Any other address reads 0x00.
- R2: The live bit equals the lock-detect input after a two-flop synchronizer. A change on the raw input reaches the live bit on the second clock edge after the change and shows in `rd_data` on the edge after that.
- R3: A high-to-low transition of the synchronized lock level sets that loop's lost flag, unless the flag is being held clear.
- R4: Once set, the lost flag stays 1 through any later lock levels until it is cleared. A steady low level never sets it.
- R5: While the clear-control bit is 1, the lost flag reads 0, including when falling edges occur.
- R6: If the clear-control bit returns to 0 while lock is low, the flag stays 0 and is set only by the next falling edge.
- R7: A write that sets the clear-control bit to 1 wins over a falling edge that is detected in the same clock cycle, so the flag stays 0.
- R8: A write to a status address loads only the clear-control bit, from `wr_data[0]`. Bits 2 and 1 ignore write data, and writes to other addresses change nothing.
- R9: Reset (synchronous, active high) clears the lost flags, the clear-control bits, `rd_data` and `lost2_valid`. A loop that is locked through reset does not raise a false lost flag afterwards.
- R10: `lost2_valid` is 1 exactly one clock after `ld_mux_sel` equals 2 and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_raw | input | 2 | Asynchronous lock-detect levels, bit 0 for the first loop |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 12 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 12 | Read address |
| rd_data | output | 8 | Registered read data |
| ld_mux_sel | input | 3 | Current selection of the lock-detect output mux |
| lost2_valid | output | 1 | Second loop's lost flag is meaningful |

## Verification
The bench goes after several corner cases:
- A loop that stays locked through reset. A design whose edge history reset to 1 would raise a false lost flag here.
- Releasing the clear while lock is low. A level-sensitive design would set the flag at once.
- A clear write that lands in the same cycle as a detected falling edge. If the edge won, the flag would read 1 after the clear is released.
- Writes carrying all-ones in bits 7:1 and writes to neighbouring addresses. These would expose a decoder that lets data reach the status bits or the wrong loop.

// File: rtl/pll_stat_pkg.sv
package pll_stat_pkg;
  localparam int STAT_W = 8;
  localparam int LOST_BIT = 2;
  localparam int LIVE_BIT = 1;
  localparam int CLR_BIT = 0;

  typedef struct packed {
    logic lost;
    logic live;
    logic clr;
  } chan_stat_t;

  function automatic logic [STAT_W-1:0] stat_byte(input chan_stat_t s);
    logic [STAT_W-1:0] b;
    b = '0;
    b[LOST_BIT] = s.lost;
    b[LIVE_BIT] = s.live;
    b[CLR_BIT] = s.clr;
    return b;
  endfunction
endpackage

// File: rtl/ld_sync.sv
module ld_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[k] <= 1'b0;
          else     chain[k] <= chain[k-1];
        end
      end
    end
  endgenerate

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/lost_tracker.sv
module lost_tracker (
  input  logic clk,
  input  logic rst,
  input  logic ld_s,
  input  logic wr_hit,
  input  logic wr_bit,
  output logic lost_q,
  output logic clr_q
);
  logic prev_q;
  logic fall;
  logic hold;

  // prev_q resets low, so a loop locked through reset shows no edge
  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= ld_s;
  end

  assign fall = prev_q & ~ld_s;
  assign hold = clr_q | (wr_hit & wr_bit);

  always_ff @(posedge clk) begin
    if (rst)         clr_q <= 1'b0;
    else if (wr_hit) clr_q <= wr_bit;
  end

  always_ff @(posedge clk) begin
    if (rst)       lost_q <= 1'b0;
    else if (hold) lost_q <= 1'b0;
    else if (fall) lost_q <= 1'b1;
  end

  // R5
  clr_holds_chk: assert property (@(posedge clk) disable iff (rst)
    clr_q |=> !lost_q);
  // R3
  fall_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (fall && !clr_q && !(wr_hit && wr_bit)) |=> lost_q);
  // R4
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (lost_q && !clr_q && !(wr_hit && wr_bit)) |=> lost_q);
  // R4
  no_level_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!lost_q && !fall) |=> !lost_q);
  // R7
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && wr_bit) |=> !lost_q);
endmodule

// File: rtl/stat_readout.sv
module stat_readout
  import pll_stat_pkg::*;
#(
  parameter int N_PLL = 2,
  parameter int ADDR_W = 12,
  parameter int BASE_ADDR = 'h182
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        rd_addr,
  input  chan_stat_t [N_PLL-1:0]   stat,
  output logic [STAT_W-1:0]        rd_data
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

  logic [ADDR_W-1:0] offs;
  logic [STAT_W-1:0] sel_byte;
  logic              mapped;

  assign offs = rd_addr - BASE;

  always_comb begin
    sel_byte = '0;
    mapped = 1'b0;
    for (int i = 0; i < N_PLL; i++) begin
      if (offs == ADDR_W'(i)) begin
        sel_byte = stat_byte(stat[i]);
        mapped = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= sel_byte;
  end

  // R1
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !mapped |=> (rd_data == '0));
  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rd_data[STAT_W-1:3] == '0));
endmodule

// File: rtl/pll_lock_status.sv
module pll_lock_status
  import pll_stat_pkg::*;
#(
  parameter int N_PLL = 2,
  parameter int ADDR_W = 12,
  parameter int BASE_ADDR = 'h182,
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W = 3,
  parameter int VALID_SEL = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PLL-1:0]  ld_raw,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic [SEL_W-1:0]  ld_mux_sel,
  output logic              lost2_valid
);
  chan_stat_t [N_PLL-1:0] stat;
  logic [N_PLL-1:0]       ld_s;
  logic [N_PLL-1:0]       hit;

  generate
    for (genvar i = 0; i < N_PLL; i++) begin : g_chan
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BASE_ADDR + i);

      ld_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d_async(ld_raw[i]),
        .d_sync (ld_s[i])
      );

      assign hit[i] = wr_en && (wr_addr == MY_ADDR);

      lost_tracker u_trk (
        .clk   (clk),
        .rst   (rst),
        .ld_s  (ld_s[i]),
        .wr_hit(hit[i]),
        .wr_bit(wr_data[CLR_BIT]),
        .lost_q(stat[i].lost),
        .clr_q (stat[i].clr)
      );

      assign stat[i].live = ld_s[i];

      // R8
      clr_load_chk: assert property (@(posedge clk) disable iff (rst)
        hit[i] |=> (stat[i].clr == $past(wr_data[CLR_BIT])));
      // R8
      clr_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !hit[i] |=> $stable(stat[i].clr));
    end
  endgenerate

  stat_readout #(
    .N_PLL    (N_PLL),
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR)
  ) u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd_addr(rd_addr),
    .stat   (stat),
    .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) lost2_valid <= 1'b0;
    else     lost2_valid <= (ld_mux_sel == SEL_W'(VALID_SEL));
  end

  // R10
  valid_track_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (lost2_valid == ($past(ld_mux_sel) == SEL_W'(VALID_SEL))));
endmodule

// File: tb/tb_pll_lock_status.sv
module tb_pll_lock_status;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A1 = 12'h182;
  localparam logic [11:0] A2 = 12'h183;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] ld_raw = 2'b11;
  logic wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [11:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [2:0] ld_mux_sel = '0;
  logic lost2_valid;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit started = 0;

  // behavioural reference state
  bit m_s1[2], m_s2[2], m_prev[2], m_lost[2], m_clr[2];
  logic [7:0] exp_rd = '0;
  bit exp_v = 0;

  pll_lock_status dut (
    .clk(clk), .rst(rst), .ld_raw(ld_raw), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ld_mux_sel(ld_mux_sel), .lost2_valid(lost2_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] model_read(input logic [11:0] a);
    for (int i = 0; i < 2; i++)
      if (a == A1 + 12'(i)) return {5'b0, m_lost[i], m_s2[i], m_clr[i]};
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    cycles++;
    started = 1;
    if (rst) begin
      for (int i = 0; i < 2; i++) begin
        m_s1[i] = 0; m_s2[i] = 0; m_prev[i] = 0; m_lost[i] = 0; m_clr[i] = 0;
      end
      exp_rd = 8'h00;
      exp_v = 0;
    end else begin
      exp_rd = model_read(rd_addr);
      exp_v = (ld_mux_sel == 3'd2);
      for (int i = 0; i < 2; i++) begin
        bit h, hold, fl;
        h = wr_en && (wr_addr == A1 + 12'(i));
        hold = m_clr[i] || (h && wr_data[0]);
        fl = m_prev[i] && !m_s2[i];
        if (hold) m_lost[i] = 0;
        else if (fl) m_lost[i] = 1;
        if (h) m_clr[i] = wr_data[0];
        m_prev[i] = m_s2[i];
        m_s2[i] = m_s1[i];
        m_s1[i] = ld_raw[i];
      end
    end
  end

  // every-clock comparison against the reference (R1, R10)
  always @(negedge clk) begin
    if (started) begin
      n_cmp++;
      if (rd_data !== exp_rd) begin
        n_bad++;
        $display("FAIL R1 per-cycle rd_data: actual %h expected %h at cycle %0d", rd_data, exp_rd, cycles);
      end
      n_cmp++;
      if (lost2_valid !== exp_v) begin
        n_bad++;
        $display("FAIL R10 per-cycle lost2_valid: actual %0b expected %0b at cycle %0d", lost2_valid, exp_v, cycles);
      end
    end
  end

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = 8'h00;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    n_cmp++;
    if (rd_data !== e) begin
      n_bad++;
      $display("FAIL %s read %h: actual %h expected %h", tag, a, rd_data, e);
    end
  endtask

  initial begin
    // R9: both loops locked across reset
    idle(3);
    rst = 0;
    rd_chk(A1, 8'h00, "R9 first read after reset");
    idle(4);
    rd_chk(A1, 8'h02, "R9 no false lost after reset");
    rd_chk(A2, 8'h02, "R9 loop2 no false lost");
    rd_chk(12'h181, 8'h00, "R1 unmapped below");
    rd_chk(12'h184, 8'h00, "R1 unmapped above");

    // R3 / R2: loop1 loses lock
    @(negedge clk); ld_raw[0] = 0;
    idle(4);
    rd_chk(A1, 8'h04, "R3 lost set, live low");
    // R4: relock keeps sticky flag
    @(negedge clk); ld_raw[0] = 1;
    idle(4);
    rd_chk(A1, 8'h06, "R4 sticky after relock");
    rd_chk(A2, 8'h02, "R1 loop2 untouched");

    // R8: write with all upper bits set loads only clear bit
    wr(A1, 8'hFE);
    rd_chk(A1, 8'h06, "R8 bits 2:1 ignore data");
    wr(12'h185, 8'hFF);
    rd_chk(A1, 8'h06, "R8 unmapped write no effect");

    // R5: clear held, edges ignored
    wr(A1, 8'h01);
    rd_chk(A1, 8'h03, "R5 clear holds flag 0");
    @(negedge clk); ld_raw[0] = 0;
    idle(4);
    rd_chk(A1, 8'h01, "R5 fall while clear held");
    // R6: release while low
    wr(A1, 8'h00);
    idle(3);
    rd_chk(A1, 8'h00, "R6 release while low stays clear");
    @(negedge clk); ld_raw[0] = 1;
    idle(4);
    @(negedge clk); ld_raw[0] = 0;
    idle(4);
    rd_chk(A1, 8'h04, "R6 next fall sets");

    // R7: clear write in the cycle the fall is detected (loop2)
    wr(A2, 8'h00);
    @(negedge clk); ld_raw[1] = 0;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1; wr_addr = A2; wr_data = 8'h01;
    @(negedge clk);
    wr_en = 0; wr_data = 8'h00;
    wr(A2, 8'h00);
    idle(2);
    rd_chk(A2, 8'h00, "R7 clear beats same-cycle fall");
    rd_chk(A1, 8'h04, "R8 loop1 unaffected by loop2 write");

    // R2: live follows raw level
    @(negedge clk); ld_raw[1] = 1;
    idle(3);
    rd_chk(A2, 8'h02, "R2 live high");

    // R10
    @(negedge clk); ld_mux_sel = 3'd2;
    @(negedge clk);
    n_cmp++;
    if (lost2_valid !== 1'b1) begin
      n_bad++;
      $display("FAIL R10 valid high: actual %0b expected 1", lost2_valid);
    end
    @(negedge clk); ld_mux_sel = 3'd1;
    @(negedge clk);
    n_cmp++;
    if (lost2_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R10 valid low: actual %0b expected 0", lost2_valid);
    end

    // mixed traffic, reference compared every cycle
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      ld_raw = 2'((k * 7 + k / 5) % 4);
      ld_mux_sel = 3'(k % 5);
      rd_addr = A1 + 12'(k % 3);
      wr_en = (k % 11 == 0);
      wr_addr = A1 + 12'(k % 4);
      wr_data = 8'((k / 11) % 2 == 0 ? 8'h01 : 8'hF0);
    end
    @(negedge clk); wr_en = 0;

    // R9: reset mid-run
    rst = 1; ld_raw = 2'b11;
    idle(2);
    rst = 0;
    idle(4);
    rd_chk(A2, 8'h02, "R9 reset clears state");

    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule